// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

The monitor watches the command pins of a DDR SDRAM channel without driving them. On every rising clock edge it samples clock enable, chip select, the three strobe lines, a 2-bit bank select and a 13-bit address. It turns them into a compact command code with its bank, row or column, and mode-register fields, all registered one cycle after the sample.

Alongside the decode, the monitor keeps two kinds of state. It records which banks hold an open row, and it tracks the read or write burst most recently started. From this state it rejects commands that are well formed in isolation but wrong in context. Examples are reading a closed bank, activating an open one, refreshing while a row is open, and stopping a burst that cannot be stopped. Each rejection raises a one-cycle error strobe with a reason code. A rejected command leaves the tracked state as it was, so the monitor keeps following the bus after a fault.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset is released, the outputs show command code 0 with no error, and every bank counts as closed.
- R2: Chip select high, and chip select low with all three strobes high, both decode as code 0 (idle). They raise no error, output zero fields and leave bank and burst state unchanged.
- R3: Strobes row/col/write = 0/1/1 decode as code 1 (activate), with bank_o = bank select and addr_o = row. The bank becomes open. Activating a bank that is already open gives error code 3.
- R4: Strobes 1/0/1 decode as code 2 (read) and 1/0/0 as code 3 (write), with bank_o, addr_o = address and ap_o = address bit 10. Either command to a closed bank gives error code 2.
- R5: An accepted read or write with address bit 10 high closes its bank, so the next access to that bank is reported as a closed-bank error.
- R6: Strobes 0/1/0 decode as code 5 (precharge). With bit 10 low, only the selected bank closes and bank_o shows it. With bit 10 high, all banks close, ap_o is 1, and bank_o is 0 whatever the bank select.
- R7: Strobes 1/1/0 decode as code 4 (burst stop). It is accepted only in the BURST_LEN cycles that follow an accepted read without auto precharge. An accepted stop ends the burst. In any other case, including after a write or an auto-precharge read, it gives error code 4.
- R8: Strobes 0/0/1 decode as code 6 (auto refresh) with clock enable high, and as code 7 (self-refresh entry) with clock enable low. Address and bank inputs are ignored. Either refresh command while any bank is open gives error code 5.
- R9: Strobes 0/0/0 decode as code 8 (mode load), with addr_o = op-code. Bank select 00 gives mr_sel_o = 0 and 01 gives mr_sel_o = 1. Bank select 10 or 11 gives error code 6.
- R10: With clock enable low, any sample other than self-refresh entry decodes as code 9 (illegal) with error code 1.
- R11: A command that raises an error leaves bank and burst state unchanged.
- R12: err_o is high exactly when err_code_o is non-zero. Error code 0 means none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Sampled clock enable |
| chip_sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| bank_sel | input | 2 | Bank select |
| addr_in | input | 13 | Row, column or op-code |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Decoded bank |
| addr_o | output | 13 | Row, column or op-code |
| ap_o | output | 1 | Auto precharge / all-bank flag |
| mr_sel_o | output | 1 | Mode register select (0 base, 1 extended) |
| err_o | output | 1 | Error strobe |
| err_code_o | output | 3 | Error reason |

## Verification
The hardest case to reach is burst-stop legality. Reaching it takes a bank opened earlier, an accepted read without auto precharge, and a stop that lands inside or just past the burst window. The burst counter is not visible at the ports. Directed sequences build these orderings: a stop inside the window, a stop one cycle late, a stop after a write, a stop after an auto-precharge read, and a stop after a rejected read. A long pseudo-random command stream is then checked against an arithmetic model of bank and burst state kept in the bench. The stream is biased so that banks open and close often.

// File: rtl/ddr_mon_pkg.sv
// Shared codes for the DDR command monitor.
// Assumes: codes are stable; consumers compare against these values.
package ddr_mon_pkg;
    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_LMR  = 4'd8,
        CMD_ILL  = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ILLEGAL  = 3'd1,
        ERR_CLOSED   = 3'd2,
        ERR_OPEN     = 3'd3,
        ERR_BST      = 3'd4,
        ERR_REF_OPEN = 3'd5,
        ERR_MR_RSVD  = 3'd6
    } err_e;

    typedef enum logic [1:0] {
        BK_RD_PLAIN = 2'd0,
        BK_RD_AP    = 2'd1,
        BK_WR       = 2'd2
    } burst_kind_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
// Pure combinational decode of one sampled command slot.
// Assumes: inputs are already registered or stable at the sampling edge.
// Fields that a command does not use are driven to zero.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              clk_en,
    input  logic              chip_sel_n,
    input  logic              row_strobe_n,
    input  logic              col_strobe_n,
    input  logic              wr_en_n,
    input  logic [BA_W-1:0]   bank_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] addr,
    output logic              ap,
    output logic              mr_sel,
    output logic              mr_rsvd
);
    logic [2:0] strobes;
    assign strobes = {row_strobe_n, col_strobe_n, wr_en_n};

    // Map the strobe pattern and clock enable onto a command and its fields.
    always_comb begin
        cmd     = CMD_NOP;
        bank    = '0;
        addr    = '0;
        ap      = 1'b0;
        mr_sel  = 1'b0;
        mr_rsvd = 1'b0;
        if (!clk_en) begin
            cmd = (!chip_sel_n && strobes == 3'b001) ? CMD_SREF : CMD_ILL;
        end else if (!chip_sel_n) begin
            unique case (strobes)
                3'b111: cmd = CMD_NOP;
                3'b011: begin
                    cmd  = CMD_ACT;
                    bank = bank_sel;
                    addr = addr_in;
                end
                3'b101, 3'b100: begin
                    cmd  = (strobes[0]) ? CMD_RD : CMD_WR;
                    bank = bank_sel;
                    addr = addr_in;
                    ap   = addr_in[AP_BIT];
                end
                3'b110: cmd = CMD_BST;
                3'b010: begin
                    cmd  = CMD_PRE;
                    ap   = addr_in[AP_BIT];
                    bank = addr_in[AP_BIT] ? '0 : bank_sel;
                end
                3'b001: cmd = CMD_AREF;
                3'b000: begin
                    cmd     = CMD_LMR;
                    addr    = addr_in;
                    mr_sel  = bank_sel[0];
                    mr_rsvd = |bank_sel[BA_W-1:1];
                end
                default: cmd = CMD_ILL;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_state.sv
// Per-bank open/closed record.
// Assumes: the caller only asserts the update strobes for accepted commands.
// Closing has priority over opening in the same cycle.
module ddr_bank_state #(
    parameter int BA_W      = 2,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_en,
    input  logic [BA_W-1:0]      open_bank,
    input  logic                 close_en,
    input  logic [BA_W-1:0]      close_bank,
    input  logic                 close_all,
    output logic [NUM_BANKS-1:0] open_q
);
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        // Hold one bank's row-open flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
            end else if (close_all || (close_en && close_bank == BA_W'(i))) begin
                open_q[i] <= 1'b0;
            end else if (open_en && open_bank == BA_W'(i)) begin
                open_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_burst_track.sv
// Counts down the window of an in-flight burst and remembers its kind.
// Assumes: start and stop are never both high (caller decodes one command).
module ddr_burst_track
    import ddr_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  burst_kind_e start_kind,
    input  logic        stop,
    output logic        active,
    output burst_kind_e kind
);
    logic [CNT_W-1:0] cnt_q;

    // Load the window on a start, clear on a stop, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            kind  <= BK_RD_PLAIN;
        end else if (start) begin
            cnt_q <= CNT_W'(BURST_LEN);
            kind  <= start_kind;
        end else if (stop) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
// DDR SDRAM command bus monitor: decodes each sampled slot, checks it against
// bank and burst state, and registers the result one cycle later.
// Assumes: the bus is sampled on the rising edge; rejected commands do not
// alter tracked state.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              chip_sel_n,
    input  logic              row_strobe_n,
    input  logic              col_strobe_n,
    input  logic              wr_en_n,
    input  logic [BA_W-1:0]   bank_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ap_o,
    output logic              mr_sel_o,
    output logic              err_o,
    output logic [2:0]        err_code_o
);
    cmd_e              dec_cmd;
    logic [BA_W-1:0]   dec_bank;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_ap;
    logic              dec_mr_sel;
    logic              dec_mr_rsvd;
    logic [NUM_BANKS-1:0] bank_open;
    logic              burst_active;
    burst_kind_e       burst_kind;
    err_e              err_now;
    logic              accept;
    logic              is_rdwr;
    burst_kind_e       new_kind;

    ddr_cmd_decode #(.BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_decode (
        .clk_en       (clk_en),
        .chip_sel_n   (chip_sel_n),
        .row_strobe_n (row_strobe_n),
        .col_strobe_n (col_strobe_n),
        .wr_en_n      (wr_en_n),
        .bank_sel     (bank_sel),
        .addr_in      (addr_in),
        .cmd          (dec_cmd),
        .bank         (dec_bank),
        .addr         (dec_addr),
        .ap           (dec_ap),
        .mr_sel       (dec_mr_sel),
        .mr_rsvd      (dec_mr_rsvd)
    );

    // Judge the decoded command against the state left by earlier commands.
    always_comb begin
        err_now = ERR_NONE;
        unique case (dec_cmd)
            CMD_ILL:           err_now = ERR_ILLEGAL;
            CMD_ACT:           if (bank_open[dec_bank]) err_now = ERR_OPEN;
            CMD_RD, CMD_WR:    if (!bank_open[dec_bank]) err_now = ERR_CLOSED;
            CMD_BST:           if (!(burst_active && burst_kind == BK_RD_PLAIN))
                                   err_now = ERR_BST;
            CMD_AREF, CMD_SREF: if (|bank_open) err_now = ERR_REF_OPEN;
            CMD_LMR:           if (dec_mr_rsvd) err_now = ERR_MR_RSVD;
            default:           err_now = ERR_NONE;
        endcase
    end

    assign accept  = (err_now == ERR_NONE);
    assign is_rdwr = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);

    // Classify a starting burst for the later stop-legality check.
    always_comb begin
        if (dec_cmd == CMD_WR)  new_kind = BK_WR;
        else if (dec_ap)        new_kind = BK_RD_AP;
        else                    new_kind = BK_RD_PLAIN;
    end

    ddr_bank_state #(.BA_W(BA_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (accept && dec_cmd == CMD_ACT),
        .open_bank  (dec_bank),
        .close_en   (accept && ((is_rdwr && dec_ap) ||
                                (dec_cmd == CMD_PRE && !dec_ap))),
        .close_bank (dec_bank),
        .close_all  (accept && dec_cmd == CMD_PRE && dec_ap),
        .open_q     (bank_open)
    );

    ddr_burst_track #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && is_rdwr),
        .start_kind (new_kind),
        .stop       (accept && dec_cmd == CMD_BST),
        .active     (burst_active),
        .kind       (burst_kind)
    );

    // Register the decode and verdict for the cycle after sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= CMD_NOP;
            bank_o     <= '0;
            addr_o     <= '0;
            ap_o       <= 1'b0;
            mr_sel_o   <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= ERR_NONE;
        end else begin
            cmd_o      <= dec_cmd;
            bank_o     <= dec_bank;
            addr_o     <= dec_addr;
            ap_o       <= dec_ap;
            mr_sel_o   <= dec_mr_sel;
            err_o      <= !accept;
            err_code_o <= err_now;
        end
    end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
// Temporal checks on the monitor's outputs and tracked state.
// Assumes: bound into ddr_cmd_monitor; all signals are sampled post-update.
module ddr_cmd_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           cmd_o,
    input logic [BA_W-1:0]      bank_o,
    input logic                 ap_o,
    input logic                 err_o,
    input logic [2:0]           err_code_o,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 burst_active
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd0 |-> !err_o && $stable(bank_open));
    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd1 && !err_o |-> bank_open[bank_o]);
    // R4
    rdwr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd2 || cmd_o == 4'd3) && !err_o && !ap_o |-> bank_open[bank_o]);
    // R5
    ap_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd2 || cmd_o == 4'd3) && !err_o && ap_o |-> !bank_open[bank_o]);
    // R6
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd5 && !err_o && ap_o |-> bank_open == '0);
    // R7
    bst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd4 && !err_o |-> !burst_active);
    // R8
    ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd6 || cmd_o == 4'd7) && !err_o |-> bank_open == '0);
    // R9
    mr_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd8 && err_o |-> err_code_o == 3'd6);
    // R10
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 4'd9 |-> err_o && err_code_o == 3'd1);
    // R11
    err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> bank_open == $past(bank_open));
    // R12
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 3'd0));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_o        (cmd_o),
    .bank_o       (bank_o),
    .ap_o         (ap_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o),
    .bank_open    (bank_open),
    .burst_active (burst_active)
);

// File: tb/ddr_cmd_monitor_tb.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_tb;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        chip_sel_n = 1'b1;
    logic        row_strobe_n = 1'b1;
    logic        col_strobe_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic [12:0] addr_in = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o;
    logic        ap_o;
    logic        mr_sel_o;
    logic        err_o;
    logic [2:0]  err_code_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model of tracked state
    bit [3:0] m_open = '0;
    int       m_cnt = 0;
    int       m_kind = 0;   // 0 plain read, 1 ap read, 2 write

    always #2 clk = ~clk;

    ddr_cmd_monitor #(.BURST_LEN(BL)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
        .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
        .bank_sel(bank_sel), .addr_in(addr_in), .cmd_o(cmd_o), .bank_o(bank_o),
        .addr_o(addr_o), .ap_o(ap_o), .mr_sel_o(mr_sel_o), .err_o(err_o),
        .err_code_o(err_code_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int c, input int ap);
        case (c)
            0: return "R2";
            1: return "R3";
            2, 3: return ap ? "R5" : "R4";
            4: return "R7";
            5: return "R6";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drive one command slot, predict its result, check it, update the model.
    task automatic step(input bit cke, input bit cs, input bit ras, input bit cas,
                        input bit we, input bit [1:0] ba, input bit [12:0] a,
                        input string tag);
        int e_cmd, e_bank, e_addr, e_ap, e_ms, e_code;
        bit [2:0] s;
        string t;
        s = {ras, cas, we};
        e_cmd = 0; e_bank = 0; e_addr = 0; e_ap = 0; e_ms = 0; e_code = 0;
        if (!cke) e_cmd = (!cs && s == 3'b001) ? 7 : 9;
        else if (!cs) begin
            case (s)
                3'b011: begin e_cmd = 1; e_bank = ba; e_addr = a; end
                3'b101: begin e_cmd = 2; e_bank = ba; e_addr = a; e_ap = a[10]; end
                3'b100: begin e_cmd = 3; e_bank = ba; e_addr = a; e_ap = a[10]; end
                3'b110: e_cmd = 4;
                3'b010: begin e_cmd = 5; e_ap = a[10]; e_bank = a[10] ? 0 : ba; end
                3'b001: e_cmd = 6;
                3'b000: begin e_cmd = 8; e_addr = a; e_ms = ba[0]; end
                default: e_cmd = 0;
            endcase
        end
        case (e_cmd)
            9: e_code = 1;
            1: if (m_open[ba]) e_code = 3;
            2, 3: if (!m_open[ba]) e_code = 2;
            4: if (!(m_cnt > 0 && m_kind == 0)) e_code = 4;
            6, 7: if (m_open != 0) e_code = 5;
            8: if (ba[1]) e_code = 6;
            default: ;
        endcase
        t = (tag == "") ? tag_of(e_cmd, e_ap) : tag;
        @(negedge clk);
        clk_en = cke; chip_sel_n = cs; row_strobe_n = ras; col_strobe_n = cas;
        wr_en_n = we; bank_sel = ba; addr_in = a;
        @(posedge clk);
        #1;
        chk(t, "cmd", cmd_o, e_cmd);
        chk(t, "bank", bank_o, e_bank);
        chk(t, "addr", addr_o, e_addr);
        chk(t, "ap", ap_o, e_ap);
        chk(t, "mr_sel", mr_sel_o, e_ms);
        chk(t, "err_code", err_code_o, e_code);
        chk("R12", "err", err_o, (e_code != 0) ? 1 : 0);
        // R11: only accepted commands move the model
        if (e_code == 0) begin
            if (e_cmd == 1) m_open[ba] = 1'b1;
            if ((e_cmd == 2 || e_cmd == 3) && e_ap) m_open[ba] = 1'b0;
            if (e_cmd == 5) begin
                if (e_ap) m_open = '0; else m_open[ba] = 1'b0;
            end
        end
        if (e_code == 0 && (e_cmd == 2 || e_cmd == 3)) begin
            m_cnt = BL; m_kind = (e_cmd == 3) ? 2 : (e_ap ? 1 : 0);
        end else if (e_code == 0 && e_cmd == 4) m_cnt = 0;
        else if (m_cnt > 0) m_cnt--;
    endtask

    task automatic nop(input string tag);
        step(1, 0, 1, 1, 1, 0, 0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "cmd", cmd_o, 0);
        chk("R1", "err", err_o, 0);
        step(1, 0, 1, 0, 1, 2'd0, 13'd5, "R1");          // read of closed bank
        // R2 deselect and nop alike, fields zero
        step(1, 1, 0, 0, 0, 2'd3, 13'h1fff, "R2");
        step(1, 0, 1, 1, 1, 2'd2, 13'h0abc, "R2");
        // R3 activate, then again on open bank
        step(1, 0, 0, 1, 1, 2'd2, 13'h1abc, "R3");
        step(1, 0, 0, 1, 1, 2'd2, 13'h0001, "R3");
        // R4 read open bank, write closed bank
        step(1, 0, 1, 0, 1, 2'd2, 13'h0012, "R4");
        // R7 stop inside window after plain read
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");          // burst already ended
        step(1, 0, 1, 0, 0, 2'd1, 13'h0004, "R4");
        // R7 stop one cycle past window
        step(1, 0, 1, 0, 1, 2'd2, 13'h0008, "R7");
        repeat (BL) nop("R2");
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");
        // R7 stop at last cycle of window
        step(1, 0, 1, 0, 1, 2'd2, 13'h0008, "R7");
        repeat (BL - 1) nop("R2");
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");
        // R7 stop after write
        step(1, 0, 1, 0, 0, 2'd2, 13'h0010, "R7");
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");
        // R5/R7 auto-precharge read, stop rejected, bank now closed
        step(1, 0, 1, 0, 1, 2'd2, 13'h0400, "R5");
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R7");
        step(1, 0, 1, 0, 1, 2'd2, 13'h0000, "R5");
        // R11 rejected read starts no burst
        step(1, 0, 1, 1, 0, 2'd0, 13'd0, "R11");
        // R6 single and all-bank precharge
        step(1, 0, 0, 1, 1, 2'd0, 13'h0100, "R6");
        step(1, 0, 0, 1, 1, 2'd3, 13'h0200, "R6");
        step(1, 0, 0, 1, 0, 2'd0, 13'h0000, "R6");
        step(1, 0, 1, 0, 1, 2'd0, 13'h0000, "R6");
        step(1, 0, 0, 1, 0, 2'd1, 13'h0400, "R6");
        step(1, 0, 1, 0, 1, 2'd3, 13'h0000, "R6");
        // R8 refresh with open bank, then idle, then self refresh
        step(1, 0, 0, 1, 1, 2'd1, 13'h0033, "R8");
        step(1, 0, 0, 0, 1, 2'd2, 13'h1fff, "R8");
        step(1, 0, 0, 1, 0, 2'd1, 13'h0000, "R8");
        step(1, 0, 0, 0, 1, 2'd3, 13'h1555, "R8");
        step(0, 0, 0, 0, 1, 2'd1, 13'h0aaa, "R8");
        // R10 clock enable low otherwise
        step(0, 0, 1, 1, 1, 2'd0, 13'd0, "R10");
        step(0, 1, 0, 0, 1, 2'd0, 13'd0, "R10");
        // R9 mode loads, all bank codes
        for (int b = 0; b < 4; b++) step(1, 0, 0, 0, 0, 2'(b), 13'(13'h0123 + b), "R9");
        // exhaustive slot sweep: control x bank x bit 10
        for (int c = 0; c < 32; c++)
            for (int b = 0; b < 4; b++)
                for (int p = 0; p < 2; p++)
                    step(c[4], c[3], c[2], c[1], c[0], 2'(b), {2'b0, p[0], 10'(c * 7 + b)}, "");
        // pseudo-random stream biased to clock enable high and chip select low
        lf = 32'h1badcafe;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[0] | lf[1] | lf[2], lf[3] & lf[4], lf[5], lf[6], lf[7],
                 lf[9:8], lf[22:10], "");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule